// File: doc/BRIEF.md
# Reed-Solomon Parity Engine for NAND Sectors

This block computes Reed-Solomon check symbols over a 512-byte flash sector while the sector bytes stream through a byte-wide valid/data port. Each byte is zero-extended to a 10-bit symbol of GF(2^10) (field polynomial x^10 + x^3 + 1) and absorbed in one clock by a division circuit for the degree-6 generator whose roots are alpha^0 to alpha^5, with alpha = x. After 512 bytes the six remainder symbols are the parity. A host reads them as eight 16-bit words whose low byte carries data.

In generate mode the host copies the eight words into the spare area. In check mode the host streams the 512 data bytes and then the 8 stored spare bytes. The block compares the stored parity with the recomputed parity and exposes their bitwise difference. A status bit reports whether they disagree. Locating and correcting errors is left to software.

A control write carries three action bits. Bit 7 clears the engine, bit 6 selects generate mode and bit 5 enables data feeding. Generate uses 0xE0, check uses 0xA0, and 0x00 freezes the engine for readout.

Top module: `nand_rs_ecc`

## Requirements
- R1: After reset every readable address returns 0x0000.
- R2: In generate mode, after 512 bytes, the six remainder symbols r5..r0 equal the coefficients of D(x)*x^6 mod g(x). D(x) takes the first byte as its highest-degree coefficient, and r5 is the coefficient of x^5.
- R3: The symbols form a 64-bit check view P: P[9:0]=r5, P[19:10]=r4, P[29:20]=r3, P[39:30]=r2, P[49:40]=r1, P[59:50]=r0, P[63:60]=padding. In generate mode, address k (0..7) returns, in bits 7:0, the bit-reverse of P[8k+7:8k], with the padding taken as ones.
- R4: In generate mode, bits 3:0 of address 7 always read 1111.
- R5: Bits 15:8 of every read are zero.
- R6: In check mode, after 512 data bytes and 8 stored bytes, address 8 reads 0x0080 when any of the 60 parity bits disagree and 0x0000 otherwise. A stored byte is expected in the generate-mode format.
- R7: In check mode, address k (0..7) returns P[8k+7:8k] XOR the bit-reversed stored byte k. That is the difference in the check view, unreversed, with the padding bits forced to zero. For a clean sector every byte reads zero.
- R8: A control write with bit 7 set zeroes the remainder, the byte count and the stored bytes in that cycle. A data byte offered in the same cycle is dropped.
- R9: Bytes offered after the 512th in generate mode, or after the 520th in check mode, have no effect.
- R10: While bit 5 of the last control write is clear, offered bytes have no effect and every readout holds.
- R11: Addresses 9 to 15 read 0x0000, and address 8 reads 0x0000 in generate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control word: bit 7 clear, bit 6 generate, bit 5 feed |
| din_valid | input | 1 | Data byte valid |
| din | input | 8 | Data byte |
| rd_addr | input | 4 | Read address: 0..7 parity/difference, 8 status |
| rd_data | output | 16 | Read data, combinational from registers |

## Verification
A clear and a data byte can fall in the same cycle. The bench provokes this by raising the clear strobe and the data valid together, partway into a sector. It then streams a complete fresh sector. The parity must match the reference remainder of that fresh sector alone, so an absorbed or counted stray byte shows up as a mismatch. Random and zero sectors are compared against a long-division model written in the bench, and corrupted data or spare bytes must raise the status bit.

// File: rtl/nand_rs_ecc.sv
module nand_rs_ecc #(
  parameter int SYM_W        = 10,
  parameter logic [SYM_W:0] FIELD_POLY = 11'h409,
  parameter int NPAR         = 6,
  parameter int SECTOR_BYTES = 512,
  parameter int SPARE_BYTES  = 8,
  parameter int ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              din_valid,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  localparam int TOTAL = SECTOR_BYTES + SPARE_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam int PW    = NPAR * SYM_W;
  localparam int PKW   = SPARE_BYTES * 8;
  localparam logic [PKW-1:0] PMASK = {{(PKW-PW){1'b0}}, {PW{1'b1}}};

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [PW-1:0] make_gen();
    logic [SYM_W-1:0] c [NPAR+1];
    logic [SYM_W-1:0] root;
    logic [PW-1:0] r;
    for (int k = 0; k <= NPAR; k++) c[k] = '0;
    c[0] = 1;
    root = 1;
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(c[k], root);
      c[0] = gf_mul(c[0], root);
      root = gf_mul(root, 2);
    end
    for (int k = 0; k < NPAR; k++) r[k*SYM_W +: SYM_W] = c[k];
    return r;
  endfunction

  localparam logic [PW-1:0] GCOEF = make_gen();

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  logic [SYM_W-1:0] rem_q [NPAR];
  logic [CNT_W-1:0] cnt_q;
  logic [PKW-1:0]   spare_q;
  logic             gen_q, feed_q;

  wire clr      = ctl_we & ctl_wdata[7];
  wire in_data  = feed_q & din_valid & (cnt_q < CNT_W'(SECTOR_BYTES));
  wire in_spare = feed_q & din_valid & ~gen_q & (cnt_q >= CNT_W'(SECTOR_BYTES)) & (cnt_q < CNT_W'(TOTAL));
  wire [SYM_W-1:0] fb = {{(SYM_W-8){1'b0}}, din} ^ rem_q[NPAR-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAR; i++) rem_q[i] <= '0;
      cnt_q   <= '0;
      spare_q <= '0;
      gen_q   <= 1'b0;
      feed_q  <= 1'b0;
    end else begin
      if (ctl_we) begin
        gen_q  <= ctl_wdata[6];
        feed_q <= ctl_wdata[5];
      end
      if (clr) begin
        for (int i = 0; i < NPAR; i++) rem_q[i] <= '0;
        cnt_q   <= '0;
        spare_q <= '0;
      end else begin
        if (in_data) begin
          rem_q[0] <= gf_mul(GCOEF[0 +: SYM_W], fb);
          for (int i = 1; i < NPAR; i++)
            rem_q[i] <= rem_q[i-1] ^ gf_mul(GCOEF[i*SYM_W +: SYM_W], fb);
        end
        for (int k = 0; k < SPARE_BYTES; k++)
          if (in_spare && cnt_q == CNT_W'(SECTOR_BYTES + k)) spare_q[8*k +: 8] <= din;
        if (in_data || in_spare) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  logic [PKW-1:0] calc_p, stor_p, diff_p, gen_view;
  always_comb begin
    calc_p = '0;
    for (int i = 0; i < NPAR; i++) calc_p[(NPAR-1-i)*SYM_W +: SYM_W] = rem_q[i];
    for (int k = 0; k < SPARE_BYTES; k++) stor_p[8*k +: 8] = rev8(spare_q[8*k +: 8]);
  end
  assign diff_p   = (calc_p ^ stor_p) & PMASK;
  assign gen_view = calc_p | ~PMASK;
  wire   mismatch = ~gen_q & (|diff_p);

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < SPARE_BYTES; k++)
      if (rd_addr == ADDR_W'(k))
        rd_data[7:0] = gen_q ? rev8(gen_view[8*k +: 8]) : diff_p[8*k +: 8];
    if (rd_addr == ADDR_W'(SPARE_BYTES)) rd_data[7] = mismatch;
  end

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && (calc_p == '0) && (spare_q == '0));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL));
  p_gen_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && cnt_q == CNT_W'(SECTOR_BYTES) && !clr) |=> $stable(calc_p));
  p_frozen_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_q && !clr) |=> $stable(calc_p) && $stable(cnt_q) && $stable(spare_q));
  p_pad_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && rd_addr == ADDR_W'(SPARE_BYTES-1)) |-> rd_data[3:0] == 4'hF);
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:8] == 8'h00);
endmodule

// File: tb/tb_nand_rs_ecc.sv
module tb_nand_rs_ecc;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, ctl_we = 0, din_valid = 0;
  logic [7:0] ctl_wdata = 0, din = 0;
  logic [3:0] rd_addr = 0;
  logic [15:0] rd_data;

  nand_rs_ecc dut (.clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
                   .din_valid(din_valid), .din(din), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [7:0] a_sec [512];
  logic [7:0] b_sec [512];
  logic [9:0] gpoly [7];

  function automatic logic [9:0] bmul(input logic [9:0] a, input logic [9:0] b);
    logic [19:0] prod = 0;
    for (int i = 0; i < 10; i++) if (b[i]) prod ^= 20'(a) << i;
    for (int i = 19; i >= 10; i--) if (prod[i]) prod ^= 20'h409 << (i - 10);
    return prod[9:0];
  endfunction

  function automatic logic [7:0] brev(input logic [7:0] v);
    return {v[0], v[1], v[2], v[3], v[4], v[5], v[6], v[7]};
  endfunction

  function automatic logic [63:0] ref_p(input bit use_b);
    logic [9:0] m [518];
    logic [63:0] p = 0;
    for (int i = 0; i < 518; i++) m[i] = (i < 512) ? {2'b00, (use_b ? b_sec[i] : a_sec[i])} : 10'd0;
    for (int i = 0; i < 512; i++)
      if (m[i] != 0) begin
        logic [9:0] c = m[i];
        for (int j = 1; j <= 6; j++) m[i+j] ^= bmul(gpoly[6-j], c);
      end
    for (int j = 0; j < 6; j++) p[10*j +: 10] = m[512 + j];
    return p;
  endfunction

  function automatic logic [7:0] gen_byte(input logic [63:0] p, input int k);
    logic [63:0] q = p | 64'hF000_0000_0000_0000;
    return brev(q[8*k +: 8]);
  endfunction

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] v, input bit with_byte, input logic [7:0] b);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v; din_valid = with_byte; din = b;
    @(negedge clk);
    ctl_we = 0; din_valid = 0;
  endtask

  task automatic push_sec(input bit use_b);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      din_valid = 1; din = use_b ? b_sec[i] : a_sec[i];
    end
    @(negedge clk);
    din_valid = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    din_valid = 1; din = b;
    @(negedge clk);
    din_valid = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    rd_addr = 4'(a);
    #1 v = rd_data;
  endtask

  task automatic check_gen(input logic [63:0] p, input string tag);
    logic [15:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(k, v);
      chk(v, {8'h00, gen_byte(p, k)}, tag);
    end
  endtask

  task automatic check_diff(input logic [63:0] d, input logic [15:0] st, input string tag);
    logic [15:0] v;
    for (int k = 0; k < 8; k++) begin
      rd(k, v);
      chk(v, {8'h00, d[8*k +: 8]}, tag);
    end
    rd(8, v);
    chk(v, st, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [63:0] pa, pb, pz;
    void'($urandom(32'h5EC7));
    for (int k = 0; k < 7; k++) gpoly[k] = 0;
    gpoly[0] = 1;
    begin
      logic [9:0] root = 1;
      for (int i = 0; i < 6; i++) begin
        for (int k = 6; k >= 1; k--) gpoly[k] = gpoly[k-1] ^ bmul(gpoly[k], root);
        gpoly[0] = bmul(gpoly[0], root);
        root = bmul(root, 10'd2);
      end
    end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin rd(a, v); chk(v, 16'h0000, "R1 reset"); end

    for (int i = 0; i < 512; i++) a_sec[i] = 8'h00;
    pz = ref_p(0);
    ctl(8'hE0, 0, 0);
    push_sec(0);
    check_gen(pz, "R2 zero sector");
    rd(7, v); chk(v, 16'h000F, "R4 pad zero sector");

    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 512; i++) a_sec[i] = 8'($urandom);
      if (t == 2) for (int i = 0; i < 512; i++) a_sec[i] = 8'hFF;
      pa = ref_p(0);
      ctl(8'hE0, 0, 0);
      push_sec(0);
      check_gen(pa, "R2 R3 R5 random sector");
      rd(7, v); chk({12'h0, v[3:0]}, 16'h000F, "R4 pad");
      rd(8, v); chk(v, 16'h0000, "R11 status in generate");
    end

    push_byte(8'h5A); push_byte(8'hC3); push_byte(8'h01);
    check_gen(pa, "R9 extra bytes in generate");

    ctl(8'h40, 0, 0);
    push_byte(8'h77); push_byte(8'h12);
    check_gen(pa, "R10 frozen generate view");
    ctl(8'h00, 0, 0);
    push_byte(8'h99);
    ctl(8'h40, 0, 0);
    check_gen(pa, "R10 frozen all-zero control");
    for (int a = 9; a < 16; a++) begin rd(a, v); chk(v, 16'h0000, "R11 unused address"); end

    for (int i = 0; i < 512; i++) b_sec[i] = 8'($urandom);
    pb = ref_p(1);
    ctl(8'hE0, 0, 0);
    for (int i = 0; i < 10; i++) push_byte(8'($urandom));
    ctl(8'hE0, 1, 8'hA5);
    push_sec(1);
    check_gen(pb, "R8 clear with simultaneous byte");

    ctl(8'hA0, 0, 0);
    push_sec(0);
    for (int k = 0; k < 8; k++) push_byte(gen_byte(pa, k));
    check_diff(64'h0, 16'h0000, "R6 R7 clean check");
    push_byte(8'hEE); push_byte(8'h3C);
    check_diff(64'h0, 16'h0000, "R9 extra bytes in check");

    for (int i = 0; i < 512; i++) b_sec[i] = a_sec[i];
    b_sec[137] = b_sec[137] ^ 8'h24;
    pb = ref_p(1);
    ctl(8'hA0, 0, 0);
    push_sec(1);
    for (int k = 0; k < 8; k++) push_byte(gen_byte(pa, k));
    check_diff((pb ^ pa) & 64'h0FFF_FFFF_FFFF_FFFF, 16'h0080, "R6 R7 data error");

    ctl(8'hA0, 0, 0);
    push_sec(0);
    for (int k = 0; k < 8; k++) push_byte(k == 3 ? gen_byte(pa, k) ^ 8'h10 : gen_byte(pa, k));
    rd(8, v); chk(v, 16'h0080, "R6 spare error");

    ctl(8'hA0, 0, 0);
    push_sec(0);
    for (int k = 0; k < 8; k++) push_byte(k == 7 ? gen_byte(pa, k) ^ 8'h0F : gen_byte(pa, k));
    rd(8, v); chk(v, 16'h0000, "R6 padding ignored");

    ctl(8'hA0, 0, 0);
    for (int a = 0; a < 9; a++) begin rd(a, v); chk(v, 16'h0000, "R8 clear zeroes"); end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule